// File: doc/BRIEF.md
# I2C Address Phase Sequencer

This block opens an I2C transaction on behalf of a host. The host presents a target address of up to ten significant bits, a direction flag and a one-cycle start request. The sequencer checks the address, asks a lower byte engine for a START condition, and then asks it to send one address byte for a short address or two for an extended one. When the phase finishes it raises a one-cycle completion pulse with a two-bit outcome code.

The byte engine is reached through a command handshake. The sequencer pulses `cmd_valid` with a command kind (START or write byte), a byte value and a stop request. The engine later pulses `eng_done` together with the acknowledge it sampled. Every command the sequencer issues keeps the stop request low, so the bus stays owned and a data phase can follow on the same transaction.

Top module: `i2c_addr_phase_seq`

## Requirements
- R1: An address below 0x80 that passes R2 is sent as one byte, with the address in bits 7:1 and the direction flag (1 = read) in bit 0.
- R2: An address below 0x80 whose bits 6:3 are all ones is invalid. No command is issued, and `done` rises two cycles after the cycle in which `go` was sampled, with status 01.
- R3: An address of 0x400 or above is invalid. No command is issued, and the outcome is status 01, as in R2.
- R4: An address from 0x80 to 0x3FF is sent as two bytes. The first is 11110, then address bits 9 and 8, then the direction flag. The second is address bits 7:0.
- R5: If the first byte of an extended address is not acknowledged (`eng_ack` = 0), the phase ends with status 10 and the second byte is never requested.
- R6: A missing acknowledge on the single short-address byte, or on the second extended byte, ends the phase with status 10. Full acknowledgement gives status 00.
- R7: `cmd_stop` is 0 on every command issued.
- R8: The first command is START (`cmd_start` = 1), and every later command is a byte write (`cmd_start` = 0). Each command waits for the engine's `eng_done` on the one before it. The acknowledge returned for START has no effect. `done` rises one cycle after the final `eng_done`.
- R9: A `go` pulse while `busy` is high is ignored. Bytes and status follow the address taken at the start of the phase.
- R10: After reset, `done`, `cmd_valid` and `busy` are 0 and `status` is 00.
- R11: `done` lasts exactly one cycle, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Start request, sampled while idle |
| addr | input | ADDR_W (12) | Target address |
| rd | input | 1 | Direction flag, 1 = read |
| busy | output | 1 | Address phase in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 OK, 01 invalid address, 10 no acknowledge |
| cmd_valid | output | 1 | One-cycle command pulse to the byte engine |
| cmd_start | output | 1 | 1 = START condition, 0 = write `cmd_byte` |
| cmd_byte | output | 8 | Byte to send |
| cmd_stop | output | 1 | Stop request after the byte |
| eng_done | input | 1 | Engine finished the last command |
| eng_ack | input | 1 | Acknowledge seen for the last byte, 1 = acknowledged |

## Verification
The first command appears two cycles after `go` is sampled. The next command appears one cycle after the engine's `eng_done`. The completion pulse follows the final `eng_done` by exactly one cycle, or follows `go` by two cycles when the address is rejected. The bench samples on the falling edge and counts cycles from the edge at which it drove `go` and from the edge at which its engine model drove `eng_done`. It compares those counts with the expected latency, and it checks that `done` is low again on the next sample. The engine model waits two cycles before answering each command, so any command issued before the previous one has finished shows up as an extra or early entry in the recorded command list.

// File: rtl/i2c_aps_pkg.sv
// Shared types for the I2C address phase sequencer.
package i2c_aps_pkg;

    // Outcome codes reported with the done pulse.
    typedef enum logic [1:0] {
        ST_OK      = 2'b00,
        ST_INVALID = 2'b01,
        ST_NOACK   = 2'b10
    } aps_status_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_START,
        S_BYTE1,
        S_BYTE2,
        S_DONE
    } aps_state_e;

    // Fixed upper five bits of the extended-address first byte.
    localparam logic [4:0] EXT_PREFIX = 5'b11110;

endpackage

// File: rtl/i2c_aps_classify.sv
// Address classifier.
// What it does: from a latched address and direction flag, decide between
// short and extended framing, flag invalid addresses, and build both bytes.
// Assumes: ADDR_W >= 10. Purely combinational.
module i2c_aps_classify
    import i2c_aps_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    output logic              invalid_o,
    output logic              ext_o,
    output logic [7:0]        byte1_o,
    output logic [7:0]        byte2_o
);
    localparam int EXT_W   = 10;
    localparam int SHORT_W = 7;

    logic over_range;
    logic reserved_short;

    // Detect addresses beyond the extended range; only exists if the port is wider.
    generate
        if (ADDR_W > EXT_W) begin : g_range
            assign over_range = |addr_i[ADDR_W-1:EXT_W];
        end else begin : g_norange
            assign over_range = 1'b0;
        end
    endgenerate

    // Choose framing and mark reserved short addresses.
    always_comb begin
        ext_o          = !over_range && (|addr_i[EXT_W-1:SHORT_W]);
        reserved_short = !over_range && !ext_o && (&addr_i[6:3]);
        invalid_o      = over_range || reserved_short;
    end

    // Assemble the bytes sent on the bus.
    always_comb begin
        if (ext_o) byte1_o = {EXT_PREFIX, addr_i[9:8], rd_i};
        else       byte1_o = {addr_i[SHORT_W-1:0], rd_i};
        byte2_o = addr_i[7:0];
    end
endmodule

// File: rtl/i2c_aps_fsm.sv
// Address phase control FSM.
// What it does: latches a request, issues START and address byte commands
// to the byte engine one at a time, and reports the outcome.
// Assumes: the engine answers eng_done at least one cycle after cmd_valid;
// eng_done outside a waiting state is ignored.
module i2c_aps_fsm
    import i2c_aps_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              invalid_i,
    input  logic              ext_i,
    input  logic [7:0]        byte1_i,
    input  logic [7:0]        byte2_i,
    input  logic              eng_done,
    input  logic              eng_ack,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rd_q,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              cmd_valid,
    output logic              cmd_start,
    output logic [7:0]        cmd_byte,
    output logic              cmd_stop
);
    aps_state_e  state_q;
    aps_status_e status_q;

    // Sequence the phase and register all outward signals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            status_q  <= ST_OK;
            addr_q    <= '0;
            rd_q      <= 1'b0;
            done      <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_start <= 1'b0;
            cmd_byte  <= '0;
            cmd_stop  <= 1'b0;
        end else begin
            done      <= 1'b0;
            cmd_valid <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (go) begin
                        addr_q  <= addr;
                        rd_q    <= rd;
                        state_q <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (invalid_i) begin
                        status_q <= ST_INVALID;
                        done     <= 1'b1;
                        state_q  <= S_DONE;
                    end else begin
                        cmd_valid <= 1'b1;
                        cmd_start <= 1'b1;
                        cmd_stop  <= 1'b0;
                        state_q   <= S_START;
                    end
                end
                S_START: begin
                    if (eng_done) begin
                        cmd_valid <= 1'b1;
                        cmd_start <= 1'b0;
                        cmd_byte  <= byte1_i;
                        cmd_stop  <= 1'b0;
                        state_q   <= S_BYTE1;
                    end
                end
                S_BYTE1: begin
                    if (eng_done) begin
                        if (!eng_ack) begin
                            status_q <= ST_NOACK;
                            done     <= 1'b1;
                            state_q  <= S_DONE;
                        end else if (ext_i) begin
                            cmd_valid <= 1'b1;
                            cmd_start <= 1'b0;
                            cmd_byte  <= byte2_i;
                            cmd_stop  <= 1'b0;
                            state_q   <= S_BYTE2;
                        end else begin
                            status_q <= ST_OK;
                            done     <= 1'b1;
                            state_q  <= S_DONE;
                        end
                    end
                end
                S_BYTE2: begin
                    if (eng_done) begin
                        status_q <= eng_ack ? ST_OK : ST_NOACK;
                        done     <= 1'b1;
                        state_q  <= S_DONE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Present busy and status.
    always_comb begin
        busy   = (state_q != S_IDLE);
        status = status_q;
    end

    // R11: the completion pulse never lasts two cycles.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: busy is low in the cycle after done.
    a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8: each command is a single-cycle pulse.
    a_r8_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R2: a rejected address completes straight from the check state, with no command.
    a_r2_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_INVALID) |-> (!cmd_valid && $past(state_q) == S_CHECK));

    // R5: a refused first byte ends the phase without another command.
    a_r5_prefix_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BYTE1 && eng_done && !eng_ack) |=> (done && !cmd_valid));

    // R9: the latched address holds for the whole phase.
    a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_q));
endmodule

// File: rtl/i2c_addr_phase_seq.sv
// I2C address phase sequencer, top level.
// What it does: validates a target address and drives a byte engine through
// START plus one or two address bytes, never requesting STOP.
// Assumes: engine handshake as described in i2c_aps_fsm.
module i2c_addr_phase_seq
    import i2c_aps_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              cmd_valid,
    output logic              cmd_start,
    output logic [7:0]        cmd_byte,
    output logic              cmd_stop,
    input  logic              eng_done,
    input  logic              eng_ack
);
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic              invalid;
    logic              ext;
    logic [7:0]        byte1;
    logic [7:0]        byte2;

    i2c_aps_classify #(.ADDR_W(ADDR_W)) u_classify (
        .addr_i    (addr_q),
        .rd_i      (rd_q),
        .invalid_o (invalid),
        .ext_o     (ext),
        .byte1_o   (byte1),
        .byte2_o   (byte2)
    );

    i2c_aps_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .addr      (addr),
        .rd        (rd),
        .invalid_i (invalid),
        .ext_i     (ext),
        .byte1_i   (byte1),
        .byte2_i   (byte2),
        .eng_done  (eng_done),
        .eng_ack   (eng_ack),
        .addr_q    (addr_q),
        .rd_q      (rd_q),
        .busy      (busy),
        .done      (done),
        .status    (status),
        .cmd_valid (cmd_valid),
        .cmd_start (cmd_start),
        .cmd_byte  (cmd_byte),
        .cmd_stop  (cmd_stop)
    );
endmodule

// File: tb/tb_i2c_addr_phase_seq.sv
module tb_i2c_addr_phase_seq;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              go = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              rd = 1'b0;
    logic              busy, done, cmd_valid, cmd_start, cmd_stop;
    logic [1:0]        status;
    logic [7:0]        cmd_byte;
    logic              eng_done = 1'b0;
    logic              eng_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    i2c_addr_phase_seq #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .go(go), .addr(addr), .rd(rd),
        .busy(busy), .done(done), .status(status),
        .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_byte(cmd_byte),
        .cmd_stop(cmd_stop), .eng_done(eng_done), .eng_ack(eng_ack)
    );

    // Stimulus and expected outcome: status 0 OK, 1 invalid, 2 no ack.
    typedef struct packed {
        logic [11:0] a;
        logic        r;
        logic        ack1;
        logic        ack2;
        logic [1:0]  st;
        logic [1:0]  ncmd;
        logic [7:0]  b1;
        logic [7:0]  b2;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{12'h050, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2, 8'hA0, 8'h00}, // R1 write
        '{12'h050, 1'b1, 1'b1, 1'b0, 2'd0, 2'd2, 8'hA1, 8'h00}, // R1 read
        '{12'h077, 1'b1, 1'b1, 1'b0, 2'd0, 2'd2, 8'hEF, 8'h00}, // R1 edge below reserved
        '{12'h000, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2, 8'h00, 8'h00}, // R1 zero
        '{12'h037, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2, 8'h6E, 8'h00}, // R1
        '{12'h078, 1'b0, 1'b1, 1'b1, 2'd1, 2'd0, 8'h00, 8'h00}, // R2 low end
        '{12'h07F, 1'b1, 1'b1, 1'b1, 2'd1, 2'd0, 8'h00, 8'h00}, // R2 high end
        '{12'h050, 1'b0, 1'b0, 1'b0, 2'd2, 2'd2, 8'hA0, 8'h00}, // R6 short nack
        '{12'h080, 1'b0, 1'b1, 1'b1, 2'd0, 2'd3, 8'hF0, 8'h80}, // R4 lowest
        '{12'h3FF, 1'b1, 1'b1, 1'b1, 2'd0, 2'd3, 8'hF7, 8'hFF}, // R4 highest
        '{12'h2A5, 1'b1, 1'b0, 1'b1, 2'd2, 2'd2, 8'hF5, 8'h00}, // R5 prefix nack
        '{12'h155, 1'b0, 1'b1, 1'b0, 2'd2, 2'd3, 8'hF2, 8'h55}, // R6 second nack
        '{12'h400, 1'b0, 1'b1, 1'b1, 2'd1, 2'd0, 8'h00, 8'h00}, // R3 boundary
        '{12'hFFF, 1'b1, 1'b1, 1'b1, 2'd1, 2'd0, 8'h00, 8'h00}  // R3 top
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Run one phase with a two-cycle engine model; optionally inject go while busy.
    task automatic run_phase(input vec_t v, input bit inject);
        logic       rs [4];
        logic [7:0] rb [4];
        logic       rp [4];
        int ncmd = 0;
        int cnt = 0;
        int cyc = 0;
        int last_done = -1;
        int done_cyc = -1;
        logic [1:0] st = 2'b11;
        @(negedge clk);
        addr = v.a; rd = v.r; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        cyc = 1;
        while (done_cyc < 0 && cyc < 200) begin
            if (done) begin
                done_cyc = cyc;
                st = status;
            end
            eng_done = 1'b0;
            eng_ack = 1'b0;
            go = 1'b0;
            if (cmd_valid) begin
                if (ncmd < 4) begin
                    rs[ncmd] = cmd_start; rb[ncmd] = cmd_byte; rp[ncmd] = cmd_stop;
                end
                ncmd++;
                cnt = 2;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    eng_done = 1'b1;
                    // START gets no ack, showing its ack is ignored (R8).
                    eng_ack = (ncmd == 2) ? v.ack1 : (ncmd == 3) ? v.ack2 : 1'b0;
                    last_done = cyc;
                end
            end
            if (inject && cyc == 3) begin
                addr = 12'h078; rd = ~v.r; go = 1'b1;
            end
            if (done_cyc < 0) begin
                @(negedge clk);
                cyc++;
            end
        end
        eng_done = 1'b0;
        chk("R6/R2/R3/R5", "status", int'(st), int'(v.st));
        chk("R2/R3/R5 R8", "command count", ncmd, int'(v.ncmd));
        if (v.st == 2'd1)
            chk("R2", "done latency after go", done_cyc, 2);
        else
            chk("R8", "done latency after eng_done", done_cyc - last_done, 1);
        for (int k = 0; k < ncmd && k < 4; k++) begin
            chk("R7", "stop flag", int'(rp[k]), 0);
            chk("R8", "command kind", int'(rs[k]), (k == 0) ? 1 : 0);
        end
        if (ncmd >= 2 && v.ncmd >= 2) chk("R1/R4", "first byte", int'(rb[1]), int'(v.b1));
        if (ncmd >= 3 && v.ncmd >= 3) chk("R4", "second byte", int'(rb[2]), int'(v.b2));
        @(negedge clk);
        chk("R11", "done width", int'(done), 0);
        chk("R11", "busy after done", int'(busy), 0);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(negedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state.
        chk("R10", "done", int'(done), 0);
        chk("R10", "cmd_valid", int'(cmd_valid), 0);
        chk("R10", "busy", int'(busy), 0);
        chk("R10", "status", int'(status), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_phase(VECS[i], 1'b0);

        // R9: go while busy, for a short and an extended address.
        run_phase(VECS[0], 1'b1);
        run_phase(VECS[9], 1'b1);

        // R10: reset in the middle of a phase returns to the idle state.
        @(negedge clk);
        addr = 12'h080; rd = 1'b0; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10", "busy after mid reset", int'(busy), 0);
        chk("R10", "cmd_valid after mid reset", int'(cmd_valid), 0);
        run_phase(VECS[1], 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule